// File: doc/BRIEF.md
# Rate-Locked Dual-Clock Elastic Buffer

This block carries a stream of 32-bit words from a fast write clock to a slower, unrelated read clock. The average rates match by construction. The producer asserts its write strobe on two of every three write-clock cycles. After a startup hold, the consumer takes one word on every read-clock cycle. The 16-entry storage absorbs phase wander between the two clocks. Each side advances its own pointer in its own clock domain. Neither pointer is used to pace the flow: pacing comes only from the fixed duty cycles.

Each side still sees a delayed view of the other side's pointer, in Gray code through a two-flop synchronizer. Each side uses that view only as a fallback guard. A write that would land in a full buffer is dropped and sets a sticky overflow flag. A read attempted while the buffer looks empty is skipped and sets a sticky underflow flag. Both flags clear only on reset.

The read side is a three-state machine:
- **RD_WAIT**: idle until a synchronized "first word written" indication arrives (transition *start_seen*).
- **RD_HOLD**: counts a fixed number of read cycles, so that about `START_DELAY` words are buffered in total (transition *hold_done*).
- **RD_RUN**: attempts a read on every cycle and stays there until reset.

The hold length is `START_DELAY` minus the four-cycle crossing latency, with a minimum of one cycle.

Top module: `rate_locked_fifo`

## Requirements
- R1: After reset, `rd_valid`, `wr_overflow` and `rd_underflow` are all 0.
- R2: While no word has been written since reset, `rd_valid` stays 0 regardless of how many read cycles pass (the reader remains in RD_WAIT).
- R3: The first `rd_valid` pulse comes through RD_HOLD. It appears between START_DELAY-2 and START_DELAY+3 read cycles after the first accepted write. With the default of 8, that window is 6 to 11 cycles.
- R4: Words leave in exactly the order they were accepted, with identical 32-bit values, across any number of pointer wraps. `rd_data` is valid in the cycle `rd_valid` is 1.
- R5: A write strobe while the write side sees 16 stored words is dropped: nothing is overwritten, so the output stays a strictly ordered subsequence of the input, and `wr_overflow` becomes 1.
- R6: A read attempt in RD_RUN while the read side sees no stored word produces no `rd_valid` pulse and sets `rd_underflow` to 1. Only the words actually written are delivered.
- R7: `wr_overflow` and `rd_underflow` remain 1 until their domain's reset, and that reset clears them.
- R8: With writes on 2 of every 3 write cycles at 1.5 times the read clock rate, the reader produces `rd_valid` on every read cycle once started, and neither guard fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock (fast side) |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Write strobe, expected on 2 of every 3 cycles |
| wr_data | input | 32 | Word to store |
| wr_overflow | output | 1 | Sticky: a write was dropped because the buffer looked full |
| rd_clk | input | 1 | Read clock (slow side) |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_valid | output | 1 | `rd_data` carries a word this cycle |
| rd_data | output | 32 | Word read out |
| rd_underflow | output | 1 | Sticky: a read was skipped because the buffer looked empty |

## Verification
The guards are the hardest behaviour to reach from the ports. In rate-locked operation they must never fire, so a correct stream never reaches them. The bench therefore breaks the rate relation on purpose in two ways. To reach the full guard, it drives the strobe on every write cycle until the buffer saturates; the written data is a running index, so any overwritten slot would show up as a step back in the output order. To reach the empty guard, it writes only four words, so the running reader drains them and then starves. Separately, a 12 000-word random stream at the exact 3:2 clock ratio is checked for order, values, gap-free delivery and startup latency.

// File: rtl/rlf_pkg.sv
package rlf_pkg;

    // Read-side control states
    typedef enum logic [1:0] {
        RD_WAIT = 2'd0,   // nothing written yet
        RD_HOLD = 2'd1,   // letting words accumulate
        RD_RUN  = 2'd2    // one read attempt per cycle
    } rd_state_e;

    // Cycles lost crossing the start indication: source register,
    // two synchronizer flops, one cycle to leave RD_WAIT
    localparam int SYNC_LAT = 4;

endpackage

// File: rtl/rlf_ptr_cross.sv
// Carries a binary counter into another clock domain:
// binary -> Gray register (source) -> two flops (destination) -> binary.
module rlf_ptr_cross #(
    parameter int W = 5
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] gray_src;
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) gray_src <= '0;
        else            gray_src <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_src;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            dst_bin[i] = ^(sync_q >> i);
        end
    end

endmodule

// File: rtl/rlf_store.sv
// Simple dual-port storage: write port on one clock, registered read on the other.
module rlf_store #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/rlf_rd_ctrl.sv
// Read-side sequencer: wait for first write, hold, then read every cycle.
module rlf_rd_ctrl
    import rlf_pkg::*;
#(
    parameter int PW       = 5,
    parameter int HOLD_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_seen,
    input  logic [PW-1:0] wptr_sync,
    output logic [PW-1:0] rptr,
    output logic          rd_do,
    output logic          valid,
    output logic          underflow,
    output rd_state_e     state
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    rd_state_e     state_q;
    rd_state_e     state_d;
    logic [CW-1:0] hold_cnt;
    logic          looks_empty;
    logic          starve;

    assign looks_empty = (wptr_sync == rptr);
    assign state       = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_WAIT: if (start_seen)                       state_d = RD_HOLD; // start_seen
            RD_HOLD: if (hold_cnt == CW'(HOLD_CYC - 1))    state_d = RD_RUN;  // hold_done
            RD_RUN:                                        state_d = RD_RUN;
            default:                                       state_d = RD_WAIT;
        endcase
    end

    // outputs of the current state
    always_comb begin
        rd_do  = (state_q == RD_RUN) && !looks_empty;
        starve = (state_q == RD_RUN) &&  looks_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            rptr      <= '0;
            valid     <= 1'b0;
            underflow <= 1'b0;
        end else begin
            hold_cnt <= (state_q == RD_HOLD) ? hold_cnt + CW'(1) : '0;
            rptr     <= rptr + PW'(rd_do);
            valid    <= rd_do;
            if (starve) underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/rate_locked_fifo.sv
module rate_locked_fifo
    import rlf_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 4,
    parameter int START_DELAY = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_overflow,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_underflow
);

    localparam int DEPTH    = 1 << AW;
    localparam int PW       = AW + 1;
    localparam int HOLD_CYC = (START_DELAY > SYNC_LAT) ? START_DELAY - SYNC_LAT : 1;

    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [PW-1:0] rptr_at_wr;
    logic [PW-1:0] wptr_at_rd;
    logic [PW-1:0] wr_level;
    logic          wr_full;
    logic          wr_do;
    logic          wr_started;
    logic          started_at_rd;
    logic          rd_do;
    rd_state_e     rd_state;

    // write domain
    assign wr_level = wptr - rptr_at_wr;
    assign wr_full  = (wr_level == PW'(DEPTH));
    assign wr_do    = wr_en && !wr_full;

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wptr        <= '0;
            wr_started  <= 1'b0;
            wr_overflow <= 1'b0;
        end else begin
            if (wr_do) begin
                wptr       <= wptr + PW'(1);
                wr_started <= 1'b1;
            end
            if (wr_en && wr_full) wr_overflow <= 1'b1;
        end
    end

    // guard views across domains
    rlf_ptr_cross #(.W(PW)) u_wptr_cross (
        .src_clk   (wr_clk),
        .src_rst_n (wr_rst_n),
        .src_bin   (wptr),
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .dst_bin   (wptr_at_rd)
    );

    rlf_ptr_cross #(.W(PW)) u_rptr_cross (
        .src_clk   (rd_clk),
        .src_rst_n (rd_rst_n),
        .src_bin   (rptr),
        .dst_clk   (wr_clk),
        .dst_rst_n (wr_rst_n),
        .dst_bin   (rptr_at_wr)
    );

    rlf_ptr_cross #(.W(1)) u_start_cross (
        .src_clk   (wr_clk),
        .src_rst_n (wr_rst_n),
        .src_bin   (wr_started),
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .dst_bin   (started_at_rd)
    );

    // read domain
    rlf_rd_ctrl #(.PW(PW), .HOLD_CYC(HOLD_CYC)) u_rd_ctrl (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .start_seen (started_at_rd),
        .wptr_sync  (wptr_at_rd),
        .rptr       (rptr),
        .rd_do      (rd_do),
        .valid      (rd_valid),
        .underflow  (rd_underflow),
        .state      (rd_state)
    );

    rlf_store #(.DW(DW), .AW(AW)) u_store (
        .wr_clk (wr_clk),
        .we     (wr_do),
        .waddr  (wptr[AW-1:0]),
        .wdata  (wr_data),
        .rd_clk (rd_clk),
        .re     (rd_do),
        .raddr  (rptr[AW-1:0]),
        .rdata  (rd_data)
    );

endmodule

// File: rtl/rate_locked_fifo_chk.sv
module rate_locked_fifo_chk
    import rlf_pkg::*;
#(
    parameter int PW    = 5,
    parameter int DEPTH = 16
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic [PW-1:0] wr_level,
    input logic          wr_overflow,
    input logic [PW-1:0] rptr,
    input rd_state_e     rd_state,
    input logic          rd_valid,
    input logic          rd_underflow
);

    AST_LEVEL_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_level <= PW'(DEPTH)); // R5

    AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overflow |=> wr_overflow); // R7

    AST_UNF_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_underflow |=> rd_underflow); // R7

    AST_VALID_FROM_RUN: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> $past(rd_state == RD_RUN)); // R3

    AST_RUN_AFTER_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_state == RD_RUN && $past(rd_state) != RD_RUN) |-> $past(rd_state) == RD_HOLD); // R3

    AST_RPTR_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rptr - $past(rptr)) <= PW'(1)); // R4

endmodule

bind rate_locked_fifo rate_locked_fifo_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .wr_level     (wr_level),
    .wr_overflow  (wr_overflow),
    .rptr         (rptr),
    .rd_state     (rd_state),
    .rd_valid     (rd_valid),
    .rd_underflow (rd_underflow)
);

// File: tb/rate_locked_fifo_tb.sv
module rate_locked_fifo_tb;
    timeunit 1ns;
    timeprecision 1fs;

    localparam int N_STREAM = 12000;
    localparam int SD       = 8;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_overflow;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_underflow;

    int checks = 0;
    int errors = 0;

    logic [31:0] sent [N_STREAM];
    logic [31:0] rx   [N_STREAM];
    int          rx_cnt = 0;
    int          gaps = 0;
    int          order_err = 0;
    logic [31:0] last_rx = '0;
    bit          lat_on = 0;
    bit          seen = 0;
    int          lat_cnt = 0;
    bit          incr_mode = 0;
    bit          gap_mode = 0;

    always #2.0 rd_clk = ~rd_clk;          // 250 MHz read clock
    always #(4.0 / 3.0) wr_clk = ~wr_clk;  // 375 MHz write clock

    rate_locked_fifo #(.DW(32), .AW(4), .START_DELAY(SD)) u_dut (
        .wr_clk       (wr_clk),
        .wr_rst_n     (wr_rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_overflow  (wr_overflow),
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .rd_underflow (rd_underflow)
    );

    // output monitor, sampled away from the active edge
    always @(negedge rd_clk) begin
        if (lat_on && !seen) begin
            lat_cnt++;
            if (rd_valid) seen = 1;
        end
        if (rd_valid) begin
            if (incr_mode && rx_cnt > 0 && rd_data <= last_rx) order_err++;
            last_rx = rd_data;
            if (rx_cnt < N_STREAM) rx[rx_cnt] = rd_data;
            rx_cnt++;
        end else if (gap_mode && seen && rx_cnt < N_STREAM) begin
            gaps++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic rd_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge rd_clk);
    endtask

    task automatic do_reset();
        @(negedge rd_clk);
        wr_en    = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        rd_cycles(4);
        rx_cnt = 0; gaps = 0; order_err = 0; last_rx = '0;
        lat_on = 0; seen = 0; lat_cnt = 0; incr_mode = 0; gap_mode = 0;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        @(negedge rd_clk);
    endtask

    function automatic logic [31:0] expected_word(input int idx);
        return sent[idx];
    endfunction

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20151));

        // ---------- reset state and idle ----------
        do_reset();
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        check(wr_overflow == 1'b0, "R1", "wr_overflow after reset", wr_overflow, 0);
        check(rd_underflow == 1'b0, "R1", "rd_underflow after reset", rd_underflow, 0);
        rd_cycles(40);
        check(rx_cnt == 0, "R2", "words out with nothing written", rx_cnt, 0);
        check(rd_underflow == 1'b0, "R2", "underflow while waiting", rd_underflow, 0);

        // ---------- rate-locked random stream ----------
        gap_mode = 1;
        begin
            int ph = 0;
            int i  = 0;
            while (i < N_STREAM) begin
                @(negedge wr_clk);
                if (ph % 3 != 2) begin
                    wr_en   = 1'b1;
                    wr_data = (i % 997 == 5) ? 32'hFFFF_FFFF : $urandom;
                    sent[i] = wr_data;
                    if (i == 0) lat_on = 1;
                    i++;
                end else begin
                    wr_en = 1'b0;
                end
                ph++;
            end
            @(negedge wr_clk);
            wr_en = 1'b0;
        end
        check(wr_overflow == 1'b0, "R8", "overflow in locked run", wr_overflow, 0);
        check(rd_underflow == 1'b0, "R8", "underflow in locked run", rd_underflow, 0);
        rd_cycles(40);
        check(rx_cnt == N_STREAM, "R4", "words delivered", rx_cnt, N_STREAM);
        begin
            int bad = 0;
            int first_bad = -1;
            for (int k = 0; k < N_STREAM; k++) begin
                if (rx[k] !== expected_word(k)) begin
                    bad++;
                    if (first_bad < 0) first_bad = k;
                end
            end
            check(bad == 0, "R4", "mismatched words (first index shown in count)", bad, 0);
            if (first_bad >= 0)
                $display("  first mismatch at %0d: %h vs %h", first_bad, rx[first_bad], sent[first_bad]);
        end
        check(lat_cnt >= SD - 2 && lat_cnt <= SD + 3, "R3", "startup latency", lat_cnt, SD);
        check(gaps == 0, "R8", "read cycles without data", gaps, 0);
        check(rd_underflow == 1'b1, "R6", "underflow after producer stops", rd_underflow, 1);

        // ---------- starved reader ----------
        do_reset();
        for (int k = 0; k < 4; k++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = 32'hA000_0000 + 32'(k);
            sent[k] = wr_data;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        rd_cycles(40);
        check(rx_cnt == 4, "R6", "words delivered when starved", rx_cnt, 4);
        begin
            int bad = 0;
            for (int k = 0; k < 4; k++) if (rx[k] !== sent[k]) bad++;
            check(bad == 0, "R6", "starved words wrong", bad, 0);
        end
        check(rd_underflow == 1'b1, "R6", "underflow flag", rd_underflow, 1);
        check(wr_overflow == 1'b0, "R6", "no overflow when starved", wr_overflow, 0);
        rd_cycles(30);
        check(rd_underflow == 1'b1 && rx_cnt == 4, "R7", "underflow sticky, no extra words",
              rx_cnt, 4);

        // ---------- flooded writer ----------
        do_reset();
        incr_mode = 1;
        for (int k = 0; k < 300; k++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = 32'(k + 1);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_overflow == 1'b1, "R5", "overflow flag when flooded", wr_overflow, 1);
        rd_cycles(40);
        check(order_err == 0, "R5", "output order breaks after dropped writes", order_err, 0);
        check(rx_cnt > 150 && rx_cnt < 300, "R5", "delivered count when flooded", rx_cnt, 200);
        check(wr_overflow == 1'b1, "R7", "overflow sticky after flood ends", wr_overflow, 1);

        do_reset();
        check(wr_overflow == 1'b0, "R7", "reset clears overflow", wr_overflow, 0);
        check(rd_underflow == 1'b0, "R7", "reset clears underflow", rd_underflow, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule